// File: doc/BRIEF.md
# Quadrature Sign-Magnitude Switch Mixer

This block sits in front of a binary-weighted switching output DAC and turns baseband I and Q samples into switch-enable words. No multiplier is used. A 2-bit phase counter runs at four times the carrier rate and stands in for four 25%-duty clock phases. In phase order, the four quarter-periods are I true, Q true, I complement and Q complement.

Each path gates its 8 magnitude bits with one quarter. The sign bit of the sample picks that quarter: the true phase for a positive sample, and the phase 180 degrees later for a negative one. The I and Q quarters never coincide. The combined switch therefore conducts for at most half of each carrier period.

Samples are taken at carrier-period boundaries only, so a word never changes inside a period. The switch-enable banks are registered, so all bits of a bank move on one edge.

Top module: `qmix_top`

## Requirements
- R1: While the reset is active, and in the first carrier period after reset is released, both banks are all zeros, whatever is on the sample inputs. The reset state is phase 0 with both held samples equal to zero.
- R2: While `run` is high, the phase steps through 0, 1, 2, 3, 0 on successive clocks. While `run` is low, the phase holds its value.
- R3: The sample inputs are captured only on an enabled step from phase 3 to phase 0. Changes on those inputs at any other time have no effect on the banks.
- R4: A sample word has the sign in bit 8 (1 = negative) and the magnitude in bits 7:0. For a positive I sample, `i_bank` equals the I magnitude in the I-true quarter (phase 0) and is zero in every other quarter.
- R5: For a negative I sample, `i_bank` equals the I magnitude in the I-complement quarter (phase 2) and is zero in every other quarter.
- R6: For a Q sample, `q_bank` equals the Q magnitude in phase 1 when the sample is positive and in phase 3 when it is negative. In every other quarter it is zero.
- R7: In no cycle are both banks non-zero at the same time.
- R8: A zero magnitude gives an all-zero bank in every quarter, whatever the sign bit.
- R9: The banks are registered. The value for phase p appears on the clock edge that moves the phase on from p. A clock edge taken with `run` low gives all-zero banks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast clock at four times the carrier rate |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously inside |
| run | input | 1 | Phase-advance enable |
| i_sample | input | 9 | I sample: bit 8 sign, bits 7:0 magnitude |
| q_sample | input | 9 | Q sample: bit 8 sign, bits 7:0 magnitude |
| i_bank | output | 8 | I-path switch enables |
| q_bank | output | 8 | Q-path switch enables |

## Verification
Two things can happen on the same edge: the capture of a new sample on the wrap from phase 3 to phase 0, and the registering of the phase-3 bank value. That bank value must still come from the old sample. The bench provokes this by presenting each new vector in the middle of a period. It then checks that the Q-complement output at the wrap edge still shows the previous vector, and that the new vector's magnitude appears only from the following edge.

// File: rtl/qmix_pkg.sv
package qmix_pkg;
  localparam int unsigned MAG_W = 8;
  localparam int unsigned PH_W  = 2;
  localparam int unsigned NPATH = 2;

  typedef enum logic [PH_W-1:0] {
    PH_I_POS = 2'd0,
    PH_Q_POS = 2'd1,
    PH_I_NEG = 2'd2,
    PH_Q_NEG = 2'd3
  } phase_e;
endpackage

// File: rtl/qmix_rst_sync.sv
module qmix_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/qmix_phase_gen.sv
module qmix_phase_gen
  import qmix_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   run,
  output phase_e phase,
  output logic   wrap
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (run) ph_d = phase_e'(ph_q + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_I_POS;
    else        ph_q <= ph_d;
  end

  assign phase = ph_q;
  assign wrap  = run && (ph_q == PH_Q_NEG);

  // R2: the last quarter is followed by the first one
  a_r2_wrap_order: assert property (@(posedge clk) disable iff (!rst_n)
    (run && ph_q == PH_Q_NEG) |=> (ph_q == PH_I_POS));
  // R2: the phase holds while stopped
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(ph_q));
endmodule

// File: rtl/qmix_sample_hold.sv
module qmix_sample_hold #(
  parameter int unsigned W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] hold_q, hold_d;

  always_comb begin
    hold_d = hold_q;
    if (load) hold_d = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  assign dout = hold_q;

  // R3: the held sample moves only on a period boundary
  a_r3_no_midperiod_change: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(hold_q));
endmodule

// File: rtl/qmix_path_gate.sv
module qmix_path_gate
  import qmix_pkg::*;
#(
  parameter int unsigned MW     = 8,
  parameter int unsigned POS_PH = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  phase_e        phase,
  input  logic          neg,
  input  logic [MW-1:0] mag,
  output logic [MW-1:0] bank
);
  localparam logic [PH_W-1:0] TRUE_PH = PH_W'(POS_PH);
  localparam logic [PH_W-1:0] COMP_PH = PH_W'((POS_PH + 2) % 4);

  logic [PH_W-1:0] sel_ph;
  logic            hit;
  logic [MW-1:0]   bank_d, bank_q;

  assign sel_ph = neg ? COMP_PH : TRUE_PH;
  assign hit    = run && (phase == sel_ph);

  for (genvar b = 0; b < MW; b++) begin : g_bit
    assign bank_d[b] = mag[b] & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank = bank_q;

  // R8: zero magnitude never conducts
  a_r8_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != '0) |-> ($past(mag) != '0));
  // R9: an edge taken while stopped leaves the bank off
  a_r9_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (bank_q == '0));
  // R4/R5/R6: conduction only in the quarter picked by the sign
  a_r6_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_q != '0) |-> ($past(phase) == $past(sel_ph)));
endmodule

// File: rtl/qmix_top.sv
module qmix_top
  import qmix_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [MAG_W:0]   i_sample,
  input  logic [MAG_W:0]   q_sample,
  output logic [MAG_W-1:0] i_bank,
  output logic [MAG_W-1:0] q_bank
);
  localparam int unsigned SW = MAG_W + 1;

  logic   rst_n_int;
  phase_e phase;
  logic   wrap;

  logic [SW-1:0]    smp_in   [NPATH];
  logic [SW-1:0]    smp_held [NPATH];
  logic [MAG_W-1:0] bank     [NPATH];

  qmix_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  qmix_phase_gen u_phase (
    .clk   (clk),
    .rst_n (rst_n_int),
    .run   (run),
    .phase (phase),
    .wrap  (wrap)
  );

  assign smp_in[0] = i_sample;
  assign smp_in[1] = q_sample;

  for (genvar p = 0; p < NPATH; p++) begin : g_path
    qmix_sample_hold #(.W(SW)) u_hold (
      .clk   (clk),
      .rst_n (rst_n_int),
      .load  (wrap),
      .din   (smp_in[p]),
      .dout  (smp_held[p])
    );

    qmix_path_gate #(.MW(MAG_W), .POS_PH(p)) u_gate (
      .clk   (clk),
      .rst_n (rst_n_int),
      .run   (run),
      .phase (phase),
      .neg   (smp_held[p][MAG_W]),
      .mag   (smp_held[p][MAG_W-1:0]),
      .bank  (bank[p])
    );
  end

  assign i_bank = bank[0];
  assign q_bank = bank[1];

  // R7: the two paths never conduct together
  a_r7_exclusive: assert property (@(posedge clk) disable iff (!rst_n_int)
    !((|i_bank) && (|q_bank)));
  // R1: both banks are off while reset is held
  a_r1_reset_off: assert property (@(posedge clk)
    !rst_n |-> (i_bank == '0 && q_bank == '0));
endmodule

// File: tb/qmix_top_tb_top.sv
module qmix_top_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 8;
  // {i_sample, q_sample}; bit 8 of each is the sign
  localparam logic [17:0] VEC [NVEC] = '{
    {9'h0A5, 9'h03C},
    {9'h1A5, 9'h03C},
    {9'h0FF, 9'h1FF},
    {9'h101, 9'h180},
    {9'h100, 9'h07E},
    {9'h000, 9'h100},
    {9'h17F, 9'h001},
    {9'h055, 9'h1AA}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       run = 1'b0;
  logic [8:0] i_sample = '0;
  logic [8:0] q_sample = '0;
  logic [7:0] i_bank, q_bank;

  int n_chk  = 0;
  int n_fail = 0;
  int bph    = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qmix_top dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run),
    .i_sample (i_sample),
    .q_sample (q_sample),
    .i_bank   (i_bank),
    .q_bank   (q_bank)
  );

  function automatic logic [7:0] exp_bank(input int path, input int p, input logic [8:0] s);
    int sel;
    sel = path + (s[8] ? 2 : 0);
    return (p == sel) ? s[7:0] : 8'h00;
  endfunction

  task automatic check(input string tag, input logic [7:0] ei, input logic [7:0] eq);
    n_chk++;
    if (i_bank !== ei || q_bank !== eq) begin
      n_fail++;
      $display("FAIL %s: actual i=%h q=%h expected i=%h q=%h", tag, i_bank, q_bank, ei, eq);
    end
  endtask

  task automatic tick();
    bit en_at_edge;
    @(posedge clk);
    en_at_edge = run;
    if (en_at_edge) bph = (bph + 1) % 4;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    run = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 reset async off", 8'h00, 8'h00);
    repeat (2) tick();
    check("R1 reset held", 8'h00, 8'h00);
    rst_n = 1'b1;
    repeat (4) tick();
    bph = 0;
  endtask

  task automatic show_summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=hung expected=finished");
    show_summary();
  end

  initial begin
    logic [8:0] prev_i, prev_q;

    do_reset();

    // R1: first period after release uses the zeroed held samples
    i_sample = 9'h0F0;
    q_sample = 9'h00F;
    run = 1'b1;
    for (int p = 0; p < 4; p++) begin
      tick();
      check("R1 first period zero", 8'h00, 8'h00);
    end

    prev_i = 9'h0F0;
    prev_q = 9'h00F;

    for (int v = 0; v < NVEC; v++) begin
      i_sample = VEC[v][17:9];
      q_sample = VEC[v][8:0];
      // R3: inputs presented mid-period; wrap edge still shows the old sample
      do begin
        int ph_before;
        ph_before = bph;
        tick();
        check("R3 old sample holds", exp_bank(0, ph_before, prev_i), exp_bank(1, ph_before, prev_q));
      end while (bph != 0);
      // R2/R4/R5/R6/R7/R8/R9: one quarter per edge, sign picks the quarter
      for (int p = 0; p < 4; p++) begin
        tick();
        check("R4 R5 R6 R7 R8 R9 quarter gating", exp_bank(0, p, VEC[v][17:9]), exp_bank(1, p, VEC[v][8:0]));
      end
      prev_i = VEC[v][17:9];
      prev_q = VEC[v][8:0];
    end

    // R2/R9: stop after phase 0 has been emitted, then resume
    tick();
    check("R4 phase 0 before stop", exp_bank(0, 0, prev_i), exp_bank(1, 0, prev_q));
    run = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R9 stopped banks off", 8'h00, 8'h00);
    end
    run = 1'b1;
    tick();
    check("R2 resumes at held phase 1", exp_bank(0, 1, prev_i), exp_bank(1, 1, prev_q));
    tick();
    check("R2 next phase 2", exp_bank(0, 2, prev_i), exp_bank(1, 2, prev_q));

    // R8: negative zero on both paths over a full period
    i_sample = 9'h100;
    q_sample = 9'h100;
    do tick(); while (bph != 0);
    for (int p = 0; p < 4; p++) begin
      tick();
      check("R8 negative zero", 8'h00, 8'h00);
    end

    // R1: reset in mid-run clears held samples
    i_sample = 9'h1C3;
    q_sample = 9'h0C3;
    tick();
    do_reset();
    run = 1'b1;
    for (int p = 0; p < 4; p++) begin
      tick();
      check("R1 restart zero period", 8'h00, 8'h00);
    end
    for (int p = 0; p < 4; p++) begin
      tick();
      check("R5 R6 after restart", exp_bank(0, p, 9'h1C3), exp_bank(1, p, 9'h0C3));
    end

    show_summary();
  end
endmodule